// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master for a three-wire serial digital-to-analog converter. A client hands it a 12-bit output code and a 2-bit power-down selection over a valid/ready handshake. The block packs them into a 16-bit word and shifts the word out, most significant bit first, on a frame-select line, a serial clock and a serial data line. All three lines are derived from the system clock by counters.

Between writes the frame-select line rests low and the serial clock rests low, which is the lowest-power idle state for the converter. Each write begins by lifting frame-select for a programmed number of system cycles. Its falling edge then opens the frame. Exactly sixteen serial clock pulses follow, and frame-select stays low through the last falling edge, so the converter never treats the write as aborted. Data changes together with each rising serial clock edge, so it is stable at the falling edge where the converter samples it.

The serial clock half-period and the frame-select high time are parameters counted in system cycles. Both are checked against the converter's minimum timing when the design is elaborated.

Top module: `dacwr_ctrl`

## Requirements
- R1: The shifted word is, first bit to last, two pad bits driven 0, then `req_mode[1]`, `req_mode[0]`, then `req_code[11]` down to `req_code[0]`. The value that `ser_dat` holds just before each `ser_clk` falling edge is the bit being delivered.
- R2: Inside a frame, `ser_dat` changes only in the same system cycle as a `ser_clk` rising edge, so it is held across every falling edge. Outside frames it is 0.
- R3: `ser_clk` is low whenever `frm_n` is high. Each frame has exactly 16 `ser_clk` falling edges, and `frm_n` does not rise while a frame has seen between 1 and 15 falling edges.
- R4: While no write is in progress, `frm_n` is low. Before every frame, `frm_n` is high for exactly `GAP_CYC` system cycles, and its falling edge opens the frame.
- R5: The first `ser_clk` rising edge of a frame comes exactly `HALF_CYC` system cycles after `frm_n` falls.
- R6: Within a frame, every high phase and every low phase of `ser_clk` lasts exactly `HALF_CYC` system cycles.
- R7: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while idle, and a request presented while busy produces no frame.
- R8: `busy` rises in the cycle after a request is taken and `req_ready` falls in that same cycle. `busy` stays high until `HALF_CYC` cycles after the sixteenth falling edge, and when `busy` falls, `frm_n` is already low.
- R9: After reset, `frm_n`, `ser_clk`, `ser_dat` and `busy` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a write |
| req_ready | output | 1 | Controller can take a write this cycle |
| req_code | input | 12 | Output code to send |
| req_mode | input | 2 | Power-down selection to send |
| frm_n | output | 1 | Frame select, active low, rests low |
| ser_clk | output | 1 | Serial clock, rests low |
| ser_dat | output | 1 | Serial data, sampled by the converter on falling `ser_clk` |
| busy | output | 1 | A write is in progress |

## Verification
The bench decodes every frame from the pins with a receiver model that latches the data value just before each falling edge. If bit order or field placement were wrong, or if data moved on the falling edge, the decoded word would not match the expected word built from the code and mode. It measures the frame-select high window, the delay from frame-select falling to the first clock rise, and the width of each clock phase. An off-by-one in any counter therefore shows up as a length of `HALF_CYC` ± 1 or `GAP_CYC` ± 1. A fifteenth or seventeenth edge, or frame-select lifting early, shows up as an abort count or a missing word. The bench also holds a second request steady through a busy period, which catches a design that queues or overwrites it. It then watches frame-select during long idle stretches, which catches a design that parks the line high.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_LEAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_TAIL  = 3'd4
  } wr_state_e;

  // Number of nanoseconds spanned by a count of system cycles.
  function automatic int span_ns(input int cycles, input int period_ns);
    return cycles * period_ns;
  endfunction

  // True when a count of system cycles covers a minimum duration.
  function automatic bit covers_ns(input int cycles, input int period_ns, input int min_ns);
    return span_ns(cycles, period_ns) >= min_ns;
  endfunction

  // Larger of two counts, used to size shared counters.
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dacwr_shreg.sv
module dacwr_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh_q <= '0;
    else if (load)   sh_q <= load_val;
    else if (shift)  sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl #(
  parameter int CODE_W      = 12,
  parameter int MODE_W      = 2,
  parameter int PAD_W       = 2,
  parameter int SYS_NS      = 20,
  parameter int HALF_CYC    = 2,
  parameter int GAP_CYC     = 2,
  parameter int MIN_SCLK_NS = 50,
  parameter int MIN_GAP_NS  = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [MODE_W-1:0] req_mode,
  output logic              frm_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy
);
  import dacwr_pkg::*;

  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int LONGEST = max2(HALF_CYC, GAP_CYC);
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int FCNT_W  = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0]  HALF_LD   = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0]  GAP_LD    = CNT_W'(GAP_CYC - 1);
  localparam logic [FCNT_W-1:0] LAST_FALL = FCNT_W'(FRAME_W - 1);

  // Elaboration-time timing checks.
  if (HALF_CYC < 1 || GAP_CYC < 1) begin : g_bad_count
    $error("dacwr_ctrl: HALF_CYC and GAP_CYC must be at least 1");
  end
  if (!covers_ns(2 * HALF_CYC, SYS_NS, MIN_SCLK_NS)) begin : g_bad_sclk
    $error("dacwr_ctrl: serial clock period below minimum");
  end
  if (!covers_ns(GAP_CYC, SYS_NS, MIN_GAP_NS)) begin : g_bad_gap
    $error("dacwr_ctrl: frame-select high time below minimum");
  end

  wr_state_e         state_q;
  logic              frm_q, sclk_q, dat_q;
  logic [FCNT_W-1:0] fall_cnt_q;

  // Named internal events, also seen by the checker.
  logic accept, tmr_done, gap_end, rise_evt, fall_evt, last_fall, tail_end;
  logic tmr_load, sh_msb;
  logic [CNT_W-1:0]   tmr_val;
  logic [FRAME_W-1:0] frame_word;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign frame_word = {{PAD_W{1'b0}}, req_mode, req_code};

  assign gap_end   = (state_q == ST_GAP)   && tmr_done;
  assign rise_evt  = ((state_q == ST_LEAD) && tmr_done) ||
                     ((state_q == ST_SHIFT) && tmr_done && !sclk_q);
  assign fall_evt  = (state_q == ST_SHIFT) && tmr_done && sclk_q;
  assign last_fall = fall_evt && (fall_cnt_q == LAST_FALL);
  assign tail_end  = (state_q == ST_TAIL)  && tmr_done;

  assign tmr_load = accept || gap_end || rise_evt || fall_evt;
  assign tmr_val  = accept ? GAP_LD : HALF_LD;

  dacwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  dacwr_shreg #(.W(FRAME_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (frame_word),
    .shift    (rise_evt),
    .msb      (sh_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      frm_q      <= 1'b0;
      sclk_q     <= 1'b0;
      dat_q      <= 1'b0;
      fall_cnt_q <= '0;
    end else begin
      if (accept) begin
        state_q    <= ST_GAP;
        frm_q      <= 1'b1;
        fall_cnt_q <= '0;
      end
      if (gap_end) begin
        state_q <= ST_LEAD;
        frm_q   <= 1'b0;
      end
      if (rise_evt) begin
        state_q <= ST_SHIFT;
        sclk_q  <= 1'b1;
        dat_q   <= sh_msb;
      end
      if (fall_evt) begin
        sclk_q     <= 1'b0;
        fall_cnt_q <= fall_cnt_q + 1'b1;
      end
      if (last_fall) state_q <= ST_TAIL;
      if (tail_end) begin
        state_q <= ST_IDLE;
        dat_q   <= 1'b0;
      end
    end
  end

  assign frm_n   = frm_q;
  assign ser_clk = sclk_q;
  assign ser_dat = dat_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/dacwr_chk.sv
module dacwr_chk #(
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic frm_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic busy,
  input logic fall_evt
);
  localparam int SW = $clog2(HALF_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic          clk_q;
  logic [SW-1:0] stab_q;
  logic [SW-1:0] lead_q;
  logic [GW-1:0] hi_q;
  logic [4:0]    fcnt_q;
  logic          clk_chg;

  assign clk_chg = (ser_clk != clk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      stab_q <= '0;
      lead_q <= '0;
      hi_q   <= '0;
      fcnt_q <= '0;
    end else begin
      clk_q <= ser_clk;
      if (clk_chg)                       stab_q <= SW'(1);
      else if (stab_q < SW'(HALF_CYC))   stab_q <= stab_q + 1'b1;
      if (frm_n)                         lead_q <= '0;
      else if (lead_q < SW'(HALF_CYC))   lead_q <= lead_q + 1'b1;
      if (!frm_n)                        hi_q <= '0;
      else if (hi_q < GW'(GAP_CYC))      hi_q <= hi_q + 1'b1;
      if (frm_n)                         fcnt_q <= '0;
      else if (fall_evt)                 fcnt_q <= fcnt_q + 1'b1;
    end
  end

  AST_DAT_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $stable(ser_dat)); // R2
  AST_CLK_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |-> !ser_clk); // R3
  AST_NO_EARLY_LIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_n) |-> (fcnt_q == 5'd0 || fcnt_q == 5'd16)); // R3
  AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= 5'd16); // R3
  AST_GAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_n) |-> (hi_q >= GW'(GAP_CYC))); // R4
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!frm_n && !ser_clk)); // R4
  AST_LEAD_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> (!frm_n && lead_q >= SW'(HALF_CYC))); // R5
  AST_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_chg && !frm_n && stab_q != '0) |-> (stab_q >= SW'(HALF_CYC))); // R6
  AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready)); // R8
endmodule

bind dacwr_ctrl dacwr_chk #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .frm_n     (frm_n),
  .ser_clk   (ser_clk),
  .ser_dat   (ser_dat),
  .busy      (busy),
  .fall_evt  (fall_evt)
);

// File: tb/dacwr_ctrl_tb_top.sv
module dacwr_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int GAP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic        frm_n, ser_clk, ser_dat, busy;

  always #10 clk = ~clk;

  dacwr_ctrl #(.HALF_CYC(HALF), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .frm_n(frm_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Pin-level receiver and timing monitor, sampled on the falling system edge.
  logic        p_frm = 0, p_clk = 0, p_dat = 0;
  logic [15:0] rx_sh = '0, rx_word = '0;
  int rx_cnt = 0, falls = 0, last_falls = 0, aborts = 0;
  int hi_run = 0, gap_len = 0, lead_run = 0, lead_len = 0, clk_run = 0;
  int hmin = 1000, hmax = 0, dat_bad = 0, clk_bad = 0, idle_hi = 0;
  bit first_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rise, fall;
      rise = ser_clk && !p_clk;
      fall = !ser_clk && p_clk;
      if (frm_n) hi_run = p_frm ? hi_run + 1 : 1;
      if (frm_n && !p_frm && falls > 0 && falls < 16) aborts++;
      if (!frm_n && p_frm) begin
        gap_len = hi_run; falls = 0; lead_run = 1; first_rise = 1;
      end else if (!frm_n && !ser_clk && first_rise) begin
        lead_run++;
      end
      if (ser_clk && frm_n) clk_bad++;
      if (frm_n && !busy) idle_hi++;
      if (ser_dat != p_dat && !rise && falls < 16) dat_bad++;
      if (rise) begin
        if (first_rise) begin lead_len = lead_run; first_rise = 0; end
        else begin
          if (clk_run < hmin) hmin = clk_run;
          if (clk_run > hmax) hmax = clk_run;
        end
        clk_run = 1;
      end else if (fall) begin
        if (clk_run < hmin) hmin = clk_run;
        if (clk_run > hmax) hmax = clk_run;
        clk_run = 1;
        rx_sh = {rx_sh[14:0], p_dat};
        falls++;
        last_falls = falls;
        if (falls == 16) begin rx_word = rx_sh; rx_cnt++; end
      end else begin
        clk_run++;
      end
      p_frm = frm_n; p_clk = ser_clk; p_dat = ser_dat;
    end
  end

  task automatic clear_stats();
    hmin = 1000; hmax = 0; dat_bad = 0; clk_bad = 0; aborts = 0;
    gap_len = 0; lead_len = 0; idle_hi = 0;
  endtask

  task automatic send(input logic [11:0] code, input logic [1:0] mode);
    @(negedge clk);
    req_valid = 1'b1; req_code = code; req_mode = mode;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 frm_n after reset", frm_n, 0);
    check("R9 ser_clk after reset", ser_clk, 0);
    check("R9 ser_dat after reset", ser_dat, 0);
    check("R9 busy after reset", busy, 0);
    check("R9 req_ready after reset", req_ready, 1);
  endtask

  task automatic t_frame(input logic [11:0] code, input logic [1:0] mode);
    int n0;
    logic [15:0] exp_word;
    exp_word = {2'b00, mode, code};
    clear_stats();
    n0 = rx_cnt;
    send(code, mode);
    check("R8 busy after take", busy, 1);
    check("R8 ready low after take", req_ready, 0);
    wait_idle();
    check("R8 frm_n low at busy fall", frm_n, 0);
    check("R8 all falls done before busy fall", last_falls, 16);
    check("R3 one word per frame", rx_cnt, n0 + 1);
    check("R1 received word", rx_word, exp_word);
    check("R3 no early lift", aborts, 0);
    check("R3 clock quiet outside frame", clk_bad, 0);
    check("R4 select high window", gap_len, GAP);
    check("R5 setup before first rise", lead_len, HALF);
    check("R6 shortest phase", hmin, HALF);
    check("R6 longest phase", hmax, HALF);
    check("R2 data moved off rising edge", dat_bad, 0);
    check("R2 data zero after frame", ser_dat, 0);
  endtask

  task automatic t_busy_request();
    int n0;
    clear_stats();
    n0 = rx_cnt;
    send(12'h3C7, 2'b01);
    req_valid = 1'b1; req_code = 12'h81E; req_mode = 2'b10;
    repeat (20) begin
      @(negedge clk);
      check("R7 ready stays low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    check("R7 request while busy ignored", rx_cnt, n0 + 1);
    check("R7 first word kept", rx_word, {4'b0001, 12'h3C7});
  endtask

  task automatic t_back_to_back();
    int n0;
    clear_stats();
    n0 = rx_cnt;
    send(12'h123, 2'b11);
    wait_idle();
    check("R1 first of pair", rx_word, {4'b0011, 12'h123});
    send(12'hEDC, 2'b00);
    wait_idle();
    check("R1 second of pair", rx_word, {4'b0000, 12'hEDC});
    check("R3 two words", rx_cnt, n0 + 2);
    check("R4 window before second frame", gap_len, GAP);
  endtask

  task automatic t_idle_low();
    clear_stats();
    repeat (60) @(negedge clk);
    check("R4 select low while idle", idle_hi, 0);
    check("R4 select pin idle", frm_n, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(12'h000, 2'b00);
    t_frame(12'hFFF, 2'b11);
    t_frame(12'hA5A, 2'b01);
    t_frame(12'h5A5, 2'b10);
    t_frame(12'h801, 2'b00);
    t_busy_request();
    t_back_to_back();
    t_idle_low();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule